// File: doc/BRIEF.md
# Strobe-Written Shared-Port Word Memory

This block is a small word memory that has no system clock at all. A write happens on an edge of a dedicated write strobe. That strobe may be a single hand-made pulse, so nothing in the block assumes a free-running clock. Reads and writes use the same bidirectional data port. The writer places a word on the port and pulses the strobe. A reader pulls the read enable low and the block then drives the addressed word back onto that same port.

An active-low select gates every access. While the select is high, strobe edges are ignored and the port is released. Reading is purely combinational: while the block is selected and read-enabled, the driven word follows the address with no clock involved. With the default parameters the array holds 32 words of 6 bits. A parameter chooses whether the write is captured on the rising or the falling strobe edge; the default is rising.

Top module: `sram_strobe`

## Requirements
- R1: The array stores 2**ADDR_W words of DATA_W bits (32 x 6 by default), selected by the ADDR_W-bit address, and every word can be written and read back independently.
- R2: While cs_n_i is high, a write strobe edge leaves every stored word unchanged.
- R3: With cs_n_i low, the rising edge of wr_stb_i (default WR_RISE=1) stores the word present on data_io into the word selected by addr_i.
- R4: With cs_n_i and rd_n_i both low, data_io carries the selected word combinationally and follows address changes with no strobe.
- R5: When cs_n_i is high or rd_n_i is high, the block does not drive data_io. Another driver's value then appears on the port unaltered.
- R6: Address and data are sampled only at the capturing strobe edge. Changes made while the strobe stays high and before it falls do not alter the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W (5) | Word address for reads and writes |
| cs_n_i | input | 1 | Select, active low; gates every access |
| wr_stb_i | input | 1 | Write strobe; its capturing edge stores a word |
| rd_n_i | input | 1 | Read enable, active low |
| data_io | inout | DATA_W (6) | Shared data port: write data in, read data out |

## Verification
The bench fills all 32 words with two different address-dependent patterns and reads every word back. A decoder that aliased address bits, or a memory that lost earlier writes, would return wrong words here. It pulses the strobe with the block deselected and confirms that the old word survives; a design that ignored the select would overwrite it. It changes the bus value while the strobe is still high and checks that the rising-edge value is the one stored; a design that latched level-sensitively or captured on the fall would keep the late value. Finally, it drives its own value onto the port while the block is deselected or read-disabled and reads that value back intact; a block that drove the port in those states would corrupt it.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;
   localparam int unsigned SS_DATA_W_DEF = 6;
   localparam int unsigned SS_ADDR_W_DEF = 5;

   typedef enum logic [1:0] {
      SS_IDLE  = 2'b00,
      SS_READ  = 2'b01,
      SS_WRITE = 2'b10
   } ss_access_e;
endpackage

// File: rtl/sram_strobe_array.sv
module sram_strobe_array #(
   parameter int unsigned DATA_W  = 6,
   parameter int unsigned ADDR_W  = 5,
   parameter bit          WR_RISE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              sel_i,
   input  logic              wr_stb_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   generate
      if (WR_RISE) begin : g_rise
         always_ff @(posedge wr_stb_i) begin
            if (sel_i) mem_q[addr_i] <= wr_data_i;
         end
      end else begin : g_fall
         always_ff @(negedge wr_stb_i) begin
            if (sel_i) mem_q[addr_i] <= wr_data_i;
         end
      end
   endgenerate

   assign rd_data_o = mem_q[addr_i];
endmodule

// File: rtl/sram_strobe_drv.sv
module sram_strobe_drv #(
   parameter int unsigned DATA_W = 6
) (
   input  sram_strobe_pkg::ss_access_e mode_i,
   input  logic [DATA_W-1:0]           word_i,
   output logic                        drive_en_o,
   inout  wire  [DATA_W-1:0]           pad_io
);
   import sram_strobe_pkg::*;

   assign drive_en_o = (mode_i == SS_READ);
   assign pad_io     = drive_en_o ? word_i : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_strobe.sv
module sram_strobe #(
   parameter int unsigned DATA_W  = sram_strobe_pkg::SS_DATA_W_DEF,
   parameter int unsigned ADDR_W  = sram_strobe_pkg::SS_ADDR_W_DEF,
   parameter bit          WR_RISE = 1'b1
) (
   input  logic              [ADDR_W-1:0] addr_i,
   input  logic                           cs_n_i,
   input  logic                           wr_stb_i,
   input  logic                           rd_n_i,
   inout  wire               [DATA_W-1:0] data_io
);
   import sram_strobe_pkg::*;

   localparam int unsigned MAX_ADDR_W = 12;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sram_strobe: DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
         $error("sram_strobe: ADDR_W out of range");
      end
   endgenerate

   logic              sel;
   logic [DATA_W-1:0] rd_word;
   logic              drive_en;
   ss_access_e        mode;

   assign sel = ~cs_n_i;

   always_comb begin
      mode = SS_IDLE;
      if (sel && !rd_n_i) mode = SS_READ;
      else if (sel && wr_stb_i) mode = SS_WRITE;
   end

   sram_strobe_array #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .WR_RISE(WR_RISE)
   ) u_array (
      .addr_i   (addr_i),
      .sel_i    (sel),
      .wr_stb_i (wr_stb_i),
      .wr_data_i(data_io),
      .rd_data_o(rd_word)
   );

   sram_strobe_drv #(
      .DATA_W(DATA_W)
   ) u_drv (
      .mode_i    (mode),
      .word_i    (rd_word),
      .drive_en_o(drive_en),
      .pad_io    (data_io)
   );
endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
   parameter int unsigned DATA_W  = 6,
   parameter int unsigned ADDR_W  = 5,
   parameter bit          WR_RISE = 1'b1
) (
   input logic [ADDR_W-1:0] addr_i,
   input logic              cs_n_i,
   input logic              wr_stb_i,
   input logic              rd_n_i,
   input logic [DATA_W-1:0] data_io,
   input logic [DATA_W-1:0] rd_word,
   input logic              drive_en
);
   logic              stb_eff;
   logic              wr_seen;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              skip_seen;
   logic [ADDR_W-1:0] skip_addr;
   logic [DATA_W-1:0] skip_old;

   assign stb_eff = WR_RISE ? wr_stb_i : ~wr_stb_i;

   initial begin
      wr_seen   = 1'b0;
      skip_seen = 1'b0;
      wr_addr   = '0;
      wr_data   = '0;
      skip_addr = '0;
      skip_old  = '0;
   end

   // Record each capturing edge: a selected write, or an ignored one.
   always @(posedge stb_eff) begin
      if (!cs_n_i) begin
         wr_seen   <= 1'b1;
         wr_addr   <= addr_i;
         wr_data   <= data_io;
         skip_seen <= 1'b0;
      end else begin
         skip_seen <= 1'b1;
         skip_addr <= addr_i;
         skip_old  <= rd_word;
      end
   end

   // Checked when the strobe returns, once the array has settled.
   always @(negedge stb_eff) begin
      if (wr_seen && addr_i == wr_addr && !skip_seen)
         assert_write_lands_R3: assert (rd_word == wr_data)
            else $error("R3: stored word differs from captured data");
      if (skip_seen && addr_i == skip_addr)
         assert_deselect_keeps_R2: assert (rd_word == skip_old)
            else $error("R2: deselected strobe modified memory");
   end

   always_comb begin
      if (drive_en)
         assert_drive_gated_R5: assert (!cs_n_i && !rd_n_i)
            else $error("R5: port driven while deselected or read-disabled");
      if (drive_en)
         assert_read_path_R4: assert (data_io == rd_word)
            else $error("R4: port value differs from addressed word");
   end
endmodule

bind sram_strobe sram_strobe_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .WR_RISE(WR_RISE)
) u_chk (
   .addr_i  (addr_i),
   .cs_n_i  (cs_n_i),
   .wr_stb_i(wr_stb_i),
   .rd_n_i  (rd_n_i),
   .data_io (data_io),
   .rd_word (rd_word),
   .drive_en(drive_en)
);

// File: tb/sram_strobe_test.sv
`timescale 1ns/1ps
module sram_strobe_test;
   localparam int DW = 6;
   localparam int AW = 5;
   localparam int NW = 1 << AW;

   logic          clk;
   logic [AW-1:0] addr;
   logic          cs_n;
   logic          wr_stb;
   logic          rd_n;
   logic          tb_en;
   logic [DW-1:0] tb_val;
   wire  [DW-1:0] bus;

   int checks;
   int errors;
   logic [DW-1:0] model [NW];

   assign bus = tb_en ? tb_val : {DW{1'bz}};

   sram_strobe uut (
      .addr_i  (addr),
      .cs_n_i  (cs_n),
      .wr_stb_i(wr_stb),
      .rd_n_i  (rd_n),
      .data_io (bus)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz pacing clock

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sel_n);
      @(negedge clk);
      rd_n = 1'b1; cs_n = sel_n; addr = a; tb_val = d; tb_en = 1'b1;
      @(negedge clk); wr_stb = 1'b1;
      @(negedge clk); wr_stb = 1'b0;
      @(negedge clk); tb_en = 1'b0; cs_n = 1'b1;
      if (!sel_n) model[a] = d;
   endtask

   task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      tb_en = 1'b0; addr = a; cs_n = 1'b0; rd_n = 1'b0;
      #2 d = bus;
      @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic t_release_idle;   // R5: deselected, read enabled
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b0; tb_en = 1'b1; tb_val = 6'h2A;
      #2 check("R5 deselected port released", bus, 6'h2A);
      tb_val = 6'h15;
      #2 check("R5 deselected port released 2", bus, 6'h15);
      @(negedge clk); tb_en = 1'b0; rd_n = 1'b1;
   endtask

   task automatic t_fill_pattern(input int k);   // R1 R3 R4
      logic [DW-1:0] got;
      for (int a = 0; a < NW; a++)
         write_word(AW'(a), DW'((a * k + 3) ^ (a >> 2)), 1'b0);
      for (int a = 0; a < NW; a++) begin
         read_word(AW'(a), got);
         check($sformatf("R1 R3 readback k=%0d addr=%0d", k, a), got, model[a]);
      end
   endtask

   task automatic t_deselected_write;   // R2
      logic [DW-1:0] got;
      write_word(5'd7, ~model[7], 1'b1);
      read_word(5'd7, got);
      check("R2 deselected strobe ignored", got, model[7]);
      write_word(5'd31, ~model[31], 1'b1);
      read_word(5'd31, got);
      check("R2 deselected strobe ignored top", got, model[31]);
   endtask

   task automatic t_read_disabled;   // R5: selected, read disabled
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b1; addr = 5'd3; tb_en = 1'b1; tb_val = ~model[3];
      #2 check("R5 read-disabled port released", bus, ~model[3]);
      @(negedge clk); tb_en = 1'b0; cs_n = 1'b1;
   endtask

   task automatic t_address_follow;   // R4
      @(negedge clk);
      tb_en = 1'b0; cs_n = 1'b0; rd_n = 1'b0; addr = 5'd10;
      #1 check("R4 addr 10", bus, model[10]);
      addr = 5'd21;
      #1 check("R4 follows to addr 21", bus, model[21]);
      addr = 5'd0;
      #1 check("R4 follows to addr 0", bus, model[0]);
      @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic t_edge_sampling;   // R6
      logic [DW-1:0] got;
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b0; addr = 5'd12; tb_en = 1'b1; tb_val = 6'h09;
      @(negedge clk); wr_stb = 1'b1;
      #1 tb_val = 6'h36; addr = 5'd13;
      @(negedge clk); wr_stb = 1'b0;
      @(negedge clk); tb_en = 1'b0; cs_n = 1'b1;
      model[12] = 6'h09;
      read_word(5'd12, got);
      check("R6 rise-edge data kept", got, 6'h09);
      read_word(5'd13, got);
      check("R6 late address not written", got, model[13]);
   endtask

   initial begin
      checks = 0; errors = 0;
      addr = '0; cs_n = 1'b1; wr_stb = 1'b0; rd_n = 1'b1; tb_en = 1'b0; tb_val = '0;
      repeat (3) @(negedge clk);
      t_release_idle();
      t_fill_pattern(5);
      t_address_follow();
      t_deselected_write();
      t_read_disabled();
      t_edge_sampling();
      t_fill_pattern(11);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule